// File: doc/BRIEF.md
# Posted Store Buffer with Read-Miss Forwarding

This block queues stores on their way from a write-through cache to a slow memory. The processor posts each store (a word address, a data word and per-byte enables) into the buffer at the same time it updates the cache. The processor is held off only when every slot is occupied. On the memory side, the oldest pending store is presented continuously. It retires on each cycle in which memory signals that it accepts a write.

Stores that are still queued have not reached memory yet, so a cache read miss would otherwise fetch stale memory contents. The block therefore has a combinational lookup port. The miss path supplies the word address and the word that memory returned. The block compares every occupied slot against that address in parallel. It then patches the memory word byte by byte, and for each byte the youngest queued store that enables that byte wins. Stores are never combined into one another. Each one drains as its own memory write.

Top module: `pstore_buf`

## Requirements
- R1: After reset the buffer holds nothing: `buf_empty` is 1, `buf_full` is 0, `buf_count` is 0 and `mem_valid` is 0.
- R2: `buf_count` rises by one for each accepted store and falls by one for each retired entry. `buf_full` is 1 exactly when the count equals the depth (4), and `buf_empty` is 1 exactly when the count is 0.
- R3: Entries retire in arrival order. While `mem_valid` is 1, `mem_addr`/`mem_data`/`mem_be` show the oldest entry, and they stay unchanged until a cycle with `mem_ready` high removes that entry.
- R4: `st_stall` is 1 when the buffer is full and `mem_ready` is 0. A store offered in that state is not taken: the count stays the same and the store never drains. With free space, `st_stall` is 0.
- R5: When the buffer is full, a store and a retirement in the same cycle both take effect. `st_stall` is 0 and the buffer stays full.
- R6: When no occupied slot holds `lk_addr`, `lk_hit` is 0 and `lk_data` equals `lk_mem_data`.
- R7: When an occupied slot holds `lk_addr`, `lk_hit` is 1. Each byte b (bits 8b+7..8b) whose enable bit b is set takes the queued data. All other bytes come from `lk_mem_data`.
- R8: When several occupied slots hold `lk_addr`, each byte comes from the youngest of those entries that enables that byte.
- R9: An entry that has retired no longer contributes to the lookup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered by the processor |
| st_addr | input | 32 | Store word address |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Store byte enables, bit b for byte b |
| st_stall | output | 1 | Store not accepted this cycle |
| mem_valid | output | 1 | Oldest entry is presented to memory |
| mem_addr | output | 32 | Oldest entry address |
| mem_data | output | 32 | Oldest entry data |
| mem_be | output | 4 | Oldest entry byte enables |
| mem_ready | input | 1 | Memory accepts the presented write |
| lk_addr | input | 32 | Read-miss word address |
| lk_mem_data | input | 32 | Word returned by memory for the miss |
| lk_data | output | 32 | Memory word patched with queued bytes |
| lk_hit | output | 1 | Some occupied slot holds the address |
| buf_full | output | 1 | All slots occupied |
| buf_empty | output | 1 | No slot occupied |
| buf_count | output | 3 | Number of occupied slots |

## Verification
Several rules are checked by the assertions on every cycle: back-pressure only when full and not draining, count steps by one, the buffer staying full under a simultaneous store and retirement, a stable head while memory is busy, and pass-through of the memory word on a lookup miss. Other behaviour can only be shown by the bench's scenarios. These are the drain order of the actual entries, the byte-by-byte patch from overlapping stores of different ages, the disappearance of retired entries from the lookup, and the absence of a rejected store from the drained stream.

// File: rtl/psb_pkg.sv
package psb_pkg;

  function automatic int unsigned cnt_bits(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction

  function automatic int unsigned ptr_bits(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

  // slot that lies k places after base on a ring of the given size
  function automatic int unsigned ring_idx(input int unsigned base,
                                           input int unsigned k,
                                           input int unsigned depth);
    int unsigned s;
    s = base + k;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

endpackage

// File: rtl/psb_ctrl.sv
module psb_ctrl #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned PTR_W = 2,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             pop_req,
  output logic             push_ok,
  output logic             pop_ok,
  output logic             stall,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wptr_nxt, rptr_nxt;
  logic [CNT_W-1:0] count_nxt;
  logic             cnt_en;

  assign full    = (count == CNT_MAX);
  assign empty   = (count == '0);
  assign pop_ok  = pop_req & ~empty;
  assign stall   = full & ~pop_req;
  assign push_ok = push_req & ~stall;
  assign cnt_en  = push_ok ^ pop_ok;

  always_comb begin
    wptr_nxt  = (wptr == LAST_SLOT) ? '0 : wptr + PTR_W'(1);
    rptr_nxt  = (rptr == LAST_SLOT) ? '0 : rptr + PTR_W'(1);
    count_nxt = push_ok ? count + CNT_W'(1) : count - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr  <= wptr_nxt;
      if (pop_ok)  rptr  <= rptr_nxt;
      if (cnt_en)  count <= count_nxt;
    end
  end

endmodule

// File: rtl/psb_store.sv
module psb_store #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BE_W   = 4,
  parameter int unsigned PTR_W  = 2
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [PTR_W-1:0]             wr_idx,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [BE_W-1:0]              wr_be,
  input  logic [PTR_W-1:0]             rd_idx,
  output logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  output logic [BE_W-1:0]              rd_be,
  output logic [DEPTH-1:0][ADDR_W-1:0] all_addr,
  output logic [DEPTH-1:0][DATA_W-1:0] all_data,
  output logic [DEPTH-1:0][BE_W-1:0]   all_be
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en & (wr_idx == PTR_W'(g));

    always_ff @(posedge clk) begin
      if (slot_we) begin
        all_addr[g] <= wr_addr;
        all_data[g] <= wr_data;
        all_be[g]   <= wr_be;
      end
    end
  end

  assign rd_addr = all_addr[rd_idx];
  assign rd_data = all_data[rd_idx];
  assign rd_be   = all_be[rd_idx];

endmodule

// File: rtl/psb_match.sv
module psb_match
  import psb_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BE_W   = 4,
  parameter int unsigned PTR_W  = 2,
  parameter int unsigned CNT_W  = 3
) (
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_addr,
  input  logic [DEPTH-1:0][DATA_W-1:0] ent_data,
  input  logic [DEPTH-1:0][BE_W-1:0]   ent_be,
  input  logic [PTR_W-1:0]             rptr,
  input  logic [CNT_W-1:0]             count,
  input  logic [ADDR_W-1:0]            lk_addr,
  input  logic [DATA_W-1:0]            mem_word,
  output logic [DATA_W-1:0]            merged,
  output logic                         hit
);

  // age-ordered view: slot k is the k-th oldest entry
  logic [DEPTH-1:0] occ_match;
  logic [DEPTH-1:0][DATA_W-1:0] age_data;
  logic [DEPTH-1:0][BE_W-1:0]   age_be;

  for (genvar k = 0; k < DEPTH; k++) begin : g_age
    localparam int unsigned KU = k;
    logic [PTR_W-1:0] src;
    assign src = PTR_W'(ring_idx(int'(rptr), KU, DEPTH));
    assign occ_match[k] = (CNT_W'(k) < count) && (ent_addr[src] == lk_addr);
    assign age_data[k]  = ent_data[src];
    assign age_be[k]    = ent_be[src];
  end

  // oldest first, so a younger enabled byte overwrites an older one
  always_comb begin
    merged = mem_word;
    for (int k = 0; k < DEPTH; k++) begin
      for (int b = 0; b < BE_W; b++) begin
        if (occ_match[k] && age_be[k][b]) merged[b*8 +: 8] = age_data[k][b*8 +: 8];
      end
    end
  end

  assign hit = |occ_match;

endmodule

// File: rtl/pstore_buf.sv
module pstore_buf
  import psb_pkg::*;
#(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BE_W   = DATA_W / 8,
  parameter int unsigned CNT_W  = cnt_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BE_W-1:0]   st_be,
  output logic              st_stall,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [BE_W-1:0]   mem_be,
  input  logic              mem_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [DATA_W-1:0] lk_mem_data,
  output logic [DATA_W-1:0] lk_data,
  output logic              lk_hit,
  output logic              buf_full,
  output logic              buf_empty,
  output logic [CNT_W-1:0]  buf_count
);

  localparam int unsigned PTR_W = ptr_bits(DEPTH);

  logic             push_ok, pop_ok;
  logic [PTR_W-1:0] wptr, rptr;
  logic [DEPTH-1:0][ADDR_W-1:0] all_addr;
  logic [DEPTH-1:0][DATA_W-1:0] all_data;
  logic [DEPTH-1:0][BE_W-1:0]   all_be;

  psb_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (st_valid),
    .pop_req  (mem_ready),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .stall    (st_stall),
    .wptr     (wptr),
    .rptr     (rptr),
    .count    (buf_count),
    .full     (buf_full),
    .empty    (buf_empty)
  );

  psb_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W),
              .PTR_W(PTR_W)) u_store (
    .clk      (clk),
    .wr_en    (push_ok),
    .wr_idx   (wptr),
    .wr_addr  (st_addr),
    .wr_data  (st_data),
    .wr_be    (st_be),
    .rd_idx   (rptr),
    .rd_addr  (mem_addr),
    .rd_data  (mem_data),
    .rd_be    (mem_be),
    .all_addr (all_addr),
    .all_data (all_data),
    .all_be   (all_be)
  );

  psb_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W),
              .PTR_W(PTR_W), .CNT_W(CNT_W)) u_match (
    .ent_addr (all_addr),
    .ent_data (all_data),
    .ent_be   (all_be),
    .rptr     (rptr),
    .count    (buf_count),
    .lk_addr  (lk_addr),
    .mem_word (lk_mem_data),
    .merged   (lk_data),
    .hit      (lk_hit)
  );

  assign mem_valid = ~buf_empty;

  // pop_ok is consumed only by the controller; keep it observable
  logic unused_pop;
  assign unused_pop = pop_ok;

endmodule

// File: rtl/pstore_buf_chk.sv
module pstore_buf_chk #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BE_W   = 4,
  parameter int unsigned CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_stall,
  input logic              mem_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic [BE_W-1:0]   mem_be,
  input logic              mem_ready,
  input logic [DATA_W-1:0] lk_mem_data,
  input logic [DATA_W-1:0] lk_data,
  input logic              lk_hit,
  input logic              buf_full,
  input logic              buf_empty,
  input logic [CNT_W-1:0]  buf_count
);

  logic take, give;
  assign take = st_valid & ~st_stall;
  assign give = mem_valid & mem_ready;

  AST_FULL_BACKPRESSURE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full && !mem_ready |-> st_stall); // R4
  AST_ROOM_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_full |-> !st_stall); // R4
  AST_COUNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
    take && !give |=> buf_count == $past(buf_count) + CNT_W'(1)); // R2
  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    give && !take |=> buf_count == $past(buf_count) - CNT_W'(1)); // R2
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_full && buf_empty)); // R2
  AST_FULL_BOTH_WAYS: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full && st_valid && mem_ready |=> buf_full); // R5
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)
      && $stable(mem_be)); // R3
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |-> !mem_valid && !lk_hit); // R9
  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_data == lk_mem_data); // R6

endmodule

bind pstore_buf pstore_buf_chk #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .st_valid    (st_valid),
  .st_stall    (st_stall),
  .mem_valid   (mem_valid),
  .mem_addr    (mem_addr),
  .mem_data    (mem_data),
  .mem_be      (mem_be),
  .mem_ready   (mem_ready),
  .lk_mem_data (lk_mem_data),
  .lk_data     (lk_data),
  .lk_hit      (lk_hit),
  .buf_full    (buf_full),
  .buf_empty   (buf_empty),
  .buf_count   (buf_count)
);

// File: tb/pstore_buf_bench.sv
module pstore_buf_bench;

  logic        clk;
  logic        rst_n;
  logic        st_valid;
  logic [31:0] st_addr, st_data;
  logic [3:0]  st_be;
  logic        st_stall;
  logic        mem_valid;
  logic [31:0] mem_addr, mem_data;
  logic [3:0]  mem_be;
  logic        mem_ready;
  logic [31:0] lk_addr, lk_mem_data, lk_data;
  logic        lk_hit;
  logic        buf_full, buf_empty;
  logic [2:0]  buf_count;

  pstore_buf u_pstore_buf (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .st_stall(st_stall),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data), .mem_be(mem_be),
    .mem_ready(mem_ready),
    .lk_addr(lk_addr), .lk_mem_data(lk_mem_data), .lk_data(lk_data), .lk_hit(lk_hit),
    .buf_full(buf_full), .buf_empty(buf_empty), .buf_count(buf_count)
  );

  typedef struct packed {
    logic [31:0] a;
    logic [31:0] d;
    logic [3:0]  be;
  } exp_t;

  exp_t q[$];
  int   n_chk  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic chk(input bit ok, input string tag, input logic [71:0] act,
                     input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // monitor: each retirement compared against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (q.size() == 0) begin
        chk(1'b0, "R3 drain with nothing expected", {mem_addr, mem_data, 4'h0, mem_be}, '0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk({mem_addr, mem_data, mem_be} == e, "R3 drain order/content",
            {mem_addr, mem_data, 4'h0, mem_be}, {e.a, e.d, 4'h0, e.be});
      end
    end
  end

  // driver: offer a store until taken, record it on acceptance
  task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
    exp_t e;
    @(posedge clk); #2;
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
    forever begin
      @(negedge clk);
      if (!st_stall) break;
      @(posedge clk); #2;
    end
    e.a = a; e.d = d; e.be = be;
    q.push_back(e);
  endtask

  task automatic idle_store();
    @(posedge clk); #2;
    st_valid = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a, input logic [31:0] m,
                        input logic [31:0] exp_d, input bit exp_h, input string tag);
    @(posedge clk); #2;
    lk_addr = a; lk_mem_data = m;
    @(negedge clk);
    chk(lk_data == exp_d && lk_hit == exp_h, tag, {39'h0, lk_hit, lk_data},
        {39'h0, exp_h, exp_d});
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; st_be = '0;
    mem_ready = 1'b0; lk_addr = 32'hFFFF_FFF0; lk_mem_data = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(buf_empty && !buf_full && buf_count == 0 && !mem_valid, "R1 reset state",
        {66'h0, buf_empty, buf_full, buf_count, mem_valid}, {66'h0, 1'b1, 1'b0, 3'd0, 1'b0});
    lookup(32'h100, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0, "R6 lookup while empty");

    // fill with memory stalled
    do_store(32'h100, 32'h1111_1111, 4'b1111);
    do_store(32'h104, 32'h2222_2222, 4'b0011);
    do_store(32'h100, 32'h3333_3333, 4'b0100);
    do_store(32'h108, 32'h4444_4444, 4'b1111);
    idle_store();
    @(negedge clk);
    chk(buf_full && !buf_empty && buf_count == 4, "R2 full after four stores",
        {67'h0, buf_full, buf_empty, buf_count}, {67'h0, 1'b1, 1'b0, 3'd4});

    // R4 a store offered while full and memory busy is refused
    @(posedge clk); #2;
    st_valid = 1'b1; st_addr = 32'h1FC; st_data = 32'h9999_9999; st_be = 4'hF;
    @(negedge clk);
    chk(st_stall == 1'b1, "R4 stall when full", {71'h0, st_stall}, {71'h0, 1'b1});
    @(posedge clk); #2;
    st_valid = 1'b0;
    @(negedge clk);
    chk(buf_count == 4, "R4 refused store not counted", {69'h0, buf_count}, {69'h0, 3'd4});
    lookup(32'h1FC, 32'h0, 32'h0, 1'b0, "R4 refused store not visible");

    // lookups over overlapping entries
    lookup(32'h100, 32'hAAAA_AAAA, 32'h1133_1111, 1'b1, "R8 youngest byte wins");
    lookup(32'h104, 32'hAAAA_AAAA, 32'hAAAA_2222, 1'b1, "R7 partial byte patch");
    lookup(32'h10C, 32'h5A5A_5A5A, 32'h5A5A_5A5A, 1'b0, "R6 no match passes memory");

    // R5 store and retirement together while full
    @(posedge clk); #2;
    mem_ready = 1'b1;
    st_valid = 1'b1; st_addr = 32'h100; st_data = 32'h5555_5555; st_be = 4'b1000;
    @(negedge clk);
    chk(st_stall == 1'b0, "R5 no stall when draining", {71'h0, st_stall}, {71'h0, 1'b0});
    q.push_back({32'h100, 32'h5555_5555, 4'b1000});
    @(posedge clk); #2;
    st_valid = 1'b0; mem_ready = 1'b0;
    @(negedge clk);
    chk(buf_full && buf_count == 4, "R5 stays full", {68'h0, buf_full, buf_count},
        {68'h0, 1'b1, 3'd4});

    // R9 oldest entry gone from lookup
    lookup(32'h100, 32'h0000_0000, 32'h5533_0000, 1'b1, "R9 retired entry ignored");

    // drain all
    @(posedge clk); #2;
    mem_ready = 1'b1;
    repeat (6) @(negedge clk);
    chk(buf_empty && buf_count == 0 && !mem_valid, "R2 empty after drain",
        {67'h0, buf_empty, buf_count, mem_valid}, {67'h0, 1'b1, 3'd0, 1'b0});
    chk(q.size() == 0, "R3 all stores drained", 72'(q.size()), 72'd0);
    lookup(32'h108, 32'h1234_5678, 32'h1234_5678, 1'b0, "R9 drained buffer no hit");

    // streaming with memory always ready
    for (int i = 0; i < 6; i++) begin
      do_store(32'h200 + 32'(i * 4), 32'hC0DE_0000 + 32'(i), 4'(i + 1));
    end
    idle_store();
    repeat (4) @(negedge clk);
    chk(buf_empty && q.size() == 0, "R3 stream drained in order",
        {70'h0, buf_empty, q.size() == 0}, {70'h0, 1'b1, 1'b1});
    @(posedge clk); #2;
    mem_ready = 1'b0;
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule